// File: doc/BRIEF.md
# Dual-Mode Control Register Port

This block puts a bank of eight 8-bit control registers behind two host access paths. The first is a multiplexed parallel bus. An address-latch strobe `ale_i` captures the register address from the shared address/data lines together with the chip select. Active-low read and write strobes then move a whole byte in one transfer. The second is a serial mode that is chosen by strapping `ale_i` high and `cs_n_i` low. In serial mode the three low bus lines carry the register address, and bus line 7 becomes a single bidirectional data pin. Bits move one per falling edge of the external shift clock `sclk_i`, least significant bit first. A serial write is committed by the rising edge of the write strobe, not by counting bits.

Every external strobe passes through a two-stage synchroniser before edge detection in the system clock domain. No flop is clocked by a host pin. The bus driver is split into a value (`ad_o`) and a per-bit output enable (`ad_oe_o`), so the pad ring builds the tri-state buffers. A parallel read enables all eight lines. A serial read enables only line 7.

The parallel engine uses these states: PAR_OFF, PAR_IDLE, PAR_SEL, PAR_READ and PAR_WRITE.
- Any state goes to PAR_OFF when serial mode is active.
- PAR_OFF goes to PAR_IDLE when serial mode ends.
- PAR_IDLE goes to PAR_SEL on an address-latch fall with chip select low.
- PAR_SEL goes back to PAR_IDLE on an address-latch fall with chip select high.
- PAR_SEL goes to PAR_READ when read goes low, or to PAR_WRITE when write goes low.
- PAR_READ returns to PAR_SEL when read goes high.
- PAR_WRITE returns to PAR_SEL on the write rise, which stores the byte.

The serial engine uses these states: SER_OFF, SER_LISTEN and SER_TALK.
- Any state goes to SER_OFF when the strap condition breaks.
- SER_OFF goes to SER_LISTEN when the strap condition has held for `STRAP_CYCLES` clocks.
- SER_LISTEN goes to SER_TALK when read is low, which loads the output shifter.
- SER_TALK returns to SER_LISTEN when read goes high.

Top module: `ctl_regport`

## Requirements
- R1: After reset all eight registers read as 0x00 and `ad_oe_o` is 0x00.
- R2: In parallel mode, the falling edge of `ale_i` captures the register address from `ad_i[2:0]` and captures the level of `cs_n_i`. Later reads and writes use that address, whatever the bus carries afterwards.
- R3: In parallel mode, with the captured chip select low, a rising edge of `wr_n_i` stores the byte on `ad_i[7:0]` into the captured register.
- R4: In parallel mode, if the captured chip select is high, writes leave every register unchanged and reads leave `ad_oe_o` at 0x00.
- R5: In parallel mode, while `rd_n_i` is low with the captured chip select low, `ad_oe_o` is 0xFF and `ad_o` is the stored value of the captured register. After `rd_n_i` rises, `ad_oe_o` returns to 0x00.
- R6: Serial mode begins only once `ale_i`=1 and `cs_n_i`=0 have held for `STRAP_CYCLES` (default 32) consecutive clocks, and it ends as soon as that condition breaks. Before then a low `rd_n_i` drives nothing. In serial mode `ad_oe_o[6:0]` stays 0.
- R7: In serial mode with `rd_n_i` high, each falling edge of `sclk_i` shifts `ad_i[7]` in, LSB first. The rising edge of `wr_n_i` loads the shifted byte into the register addressed by `ad_i[2:0]`. The value can then be read in either mode.
- R8: In serial mode, when `rd_n_i` goes low the addressed register is loaded. `ad_o[7]` first shows bit 0 and then advances one bit per falling edge of `sclk_i`. `ad_oe_o` is 0x80 only while `rd_n_i` is low and 0x00 after it rises.
- R9: When a `wr_n_i` rise and an `sclk_i` fall land in the same synchronised cycle, the committed byte is the shift content from before that cycle's shift.
- R10: There is no bit counter. If more than eight bits are shifted before the commit, the last eight shifted bits are stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ale_i | input | 1 | Address-latch strobe; held high together with cs_n_i low to strap serial mode |
| cs_n_i | input | 1 | Active-low chip select |
| rd_n_i | input | 1 | Active-low read strobe |
| wr_n_i | input | 1 | Active-low write strobe |
| sclk_i | input | 1 | External serial shift clock |
| ad_i | input | 8 | Incoming address/data lines (bit 7 is serial data in serial mode) |
| ad_o | output | 8 | Outgoing address/data values |
| ad_oe_o | output | 8 | Per-bit output enable for ad_o |

## Verification
Two serial functions can fall in the same cycle: the commit on the write-strobe rise and a shift-clock fall. The bench provokes this by changing `sclk_i` and `wr_n_i` at the same instant after a full byte has been shifted. Both inputs then travel through identical synchroniser depths and are seen together. The register is read back serially, and the bench expects the byte from before the extra shift, never the one-bit-shifted value.

// File: rtl/ctl_regport_pkg.sv
package ctl_regport_pkg;

    // Indices into the synchronised level vector
    localparam int LV_ALE = 0;
    localparam int LV_CS  = 1;
    localparam int LV_RD  = 2;
    localparam int LV_WR  = 3;
    localparam int LV_NUM = 4;

    // Indices into the edge-event vector
    localparam int EV_ALE_FALL  = 0;
    localparam int EV_WR_RISE   = 1;
    localparam int EV_SCLK_FALL = 2;
    localparam int EV_NUM       = 3;

    typedef enum logic [2:0] {
        PAR_OFF,
        PAR_IDLE,
        PAR_SEL,
        PAR_READ,
        PAR_WRITE
    } par_state_t;

    typedef enum logic [1:0] {
        SER_OFF,
        SER_LISTEN,
        SER_TALK
    } ser_state_t;

endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] pipe [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe[s] <= RST_VAL;
                end else begin
                    if (s == 0) pipe[s] <= d;
                    else        pipe[s] <= pipe[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/ctl_edge.sv
module ctl_edge #(
    parameter int           W         = 1,
    parameter int           STAGES    = 2,
    parameter logic [W-1:0] RST_VAL   = '0,
    parameter logic [W-1:0] FALL_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] evt
);

    logic [W-1:0] cur;
    logic [W-1:0] prev;

    ctl_sync #(.W(W), .STAGES(STAGES), .RST_VAL(RST_VAL)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (d),
        .q     (cur)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= cur;
    end

    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            if (FALL_MASK[b]) begin : g_fall
                assign evt[b] = prev[b] & ~cur[b];
            end else begin : g_rise
                assign evt[b] = ~prev[b] & cur[b];
            end
        end
    endgenerate

endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank #(
    parameter int AW = 3,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          par_we,
    input  logic [AW-1:0] par_addr,
    input  logic [DW-1:0] par_data,
    input  logic          ser_we,
    input  logic [AW-1:0] ser_addr,
    input  logic [DW-1:0] ser_data,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);

    localparam int NREG = 1 << AW;

    logic [DW-1:0] mem [NREG];
    logic          we;
    logic [AW-1:0] waddr;
    logic [DW-1:0] wdata;

    always_comb begin
        we    = par_we | ser_we;
        waddr = ser_we ? ser_addr : par_addr;
        wdata = ser_we ? ser_data : par_data;
    end

    generate
        for (genvar r = 0; r < NREG; r++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                    mem[r] <= '0;
                else if (we && waddr == AW'(r)) mem[r] <= wdata;
            end
        end
    endgenerate

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

    // The two engines must never write in the same cycle
    assert_one_writer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({par_we, ser_we}));

    // A write lands in the addressed register on the next cycle
    assert_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/ctl_par_engine.sv
module ctl_par_engine
    import ctl_regport_pkg::*;
#(
    parameter int AW = 3,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ser_mode,
    input  logic          ale_fall,
    input  logic          cs_lvl_n,
    input  logic          rd_lvl_n,
    input  logic          wr_lvl_n,
    input  logic          wr_rise,
    input  logic [DW-1:0] bus_d,
    output logic          we,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] drv_d,
    output logic [DW-1:0] drv_oe
);

    par_state_t    state, state_nx;
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= PAR_IDLE;
            addr_q <= '0;
        end else begin
            state <= state_nx;
            if (ale_fall && !ser_mode && state != PAR_OFF)
                addr_q <= bus_d[AW-1:0];
        end
    end

    always_comb begin
        state_nx = state;
        if (ser_mode) begin
            state_nx = PAR_OFF;
        end else begin
            unique case (state)
                PAR_OFF:   state_nx = PAR_IDLE;
                PAR_IDLE:  if (ale_fall && !cs_lvl_n) state_nx = PAR_SEL;
                PAR_SEL: begin
                    if (ale_fall)      state_nx = cs_lvl_n ? PAR_IDLE : PAR_SEL;
                    else if (!rd_lvl_n) state_nx = PAR_READ;
                    else if (!wr_lvl_n) state_nx = PAR_WRITE;
                end
                PAR_READ:  if (rd_lvl_n) state_nx = PAR_SEL;
                PAR_WRITE: if (wr_rise)  state_nx = PAR_SEL;
                default:   state_nx = PAR_IDLE;
            endcase
        end
    end

    always_comb begin
        we     = (state == PAR_WRITE) && wr_rise && !ser_mode;
        addr   = addr_q;
        wdata  = bus_d;
        drv_d  = rdata;
        drv_oe = (state == PAR_READ && !ser_mode) ? '1 : '0;
    end

    // Bus released once the read strobe has been high for a cycle
    assert_par_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lvl_n && $past(rd_lvl_n)) |-> drv_oe == '0);

    // No write ever comes from the parallel path in serial mode
    assert_par_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ser_mode |-> !we && drv_oe == '0);

endmodule

// File: rtl/ctl_ser_engine.sv
module ctl_ser_engine
    import ctl_regport_pkg::*;
#(
    parameter int AW           = 3,
    parameter int DW           = 8,
    parameter int STRAP_CYCLES = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strap_cond,
    input  logic          rd_lvl_n,
    input  logic          wr_rise,
    input  logic          sclk_fall,
    input  logic          din,
    input  logic [AW-1:0] addr_in,
    output logic          ser_mode,
    output logic          we,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    input  logic [DW-1:0] rdata,
    output logic          drv_bit,
    output logic          drv_oe
);

    localparam int CW = $clog2(STRAP_CYCLES + 1);

    ser_state_t    state, state_nx;
    logic [CW-1:0] strap_cnt;
    logic [DW-1:0] in_sh;
    logic [DW-1:0] out_sh;
    logic          load_out;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         strap_cnt <= '0;
        else if (!strap_cond)               strap_cnt <= '0;
        else if (strap_cnt != CW'(STRAP_CYCLES)) strap_cnt <= strap_cnt + 1'b1;
    end

    assign ser_mode = strap_cond && (strap_cnt == CW'(STRAP_CYCLES));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SER_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (!ser_mode) begin
            state_nx = SER_OFF;
        end else begin
            unique case (state)
                SER_OFF:    state_nx = SER_LISTEN;
                SER_LISTEN: if (!rd_lvl_n) state_nx = SER_TALK;
                SER_TALK:   if (rd_lvl_n)  state_nx = SER_LISTEN;
                default:    state_nx = SER_OFF;
            endcase
        end
    end

    assign load_out = ser_mode && (state == SER_LISTEN) && !rd_lvl_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_sh  <= '0;
            out_sh <= '0;
        end else begin
            if (ser_mode && state == SER_LISTEN && sclk_fall)
                in_sh <= {din, in_sh[DW-1:1]};
            if (load_out)
                out_sh <= rdata;
            else if (state == SER_TALK && sclk_fall)
                out_sh <= {1'b0, out_sh[DW-1:1]};
        end
    end

    always_comb begin
        we      = ser_mode && (state == SER_LISTEN) && wr_rise;
        addr    = addr_in;
        wdata   = in_sh;
        drv_bit = out_sh[0];
        drv_oe  = ser_mode && (state == SER_TALK);
    end

    // Data pin released once read has been high for a cycle
    assert_ser_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lvl_n && $past(rd_lvl_n)) |-> !drv_oe);

    // First bit driven is bit 0 of the register read at load time
    assert_ser_lsb_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_oe) |-> drv_bit == $past(rdata[0]));

    // Serial mode never precedes a full strap window
    assert_strap_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_mode) |-> $past(strap_cond));

endmodule

// File: rtl/ctl_regport.sv
module ctl_regport
    import ctl_regport_pkg::*;
#(
    parameter int AW           = 3,
    parameter int DW           = 8,
    parameter int SYNC_STAGES  = 2,
    parameter int STRAP_CYCLES = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ale_i,
    input  logic          cs_n_i,
    input  logic          rd_n_i,
    input  logic          wr_n_i,
    input  logic          sclk_i,
    input  logic [DW-1:0] ad_i,
    output logic [DW-1:0] ad_o,
    output logic [DW-1:0] ad_oe_o
);

    localparam int LVW = DW + LV_NUM;
    localparam logic [LVW-1:0]    LV_RST = {{DW{1'b0}}, 4'b1110};
    localparam logic [EV_NUM-1:0] EV_RST = 3'b110;
    localparam logic [EV_NUM-1:0] EV_FALL = 3'b101;

    logic [LVW-1:0]    lvl;
    logic [EV_NUM-1:0] evt;
    logic [DW-1:0]     bus_d;

    ctl_sync #(.W(LVW), .STAGES(SYNC_STAGES), .RST_VAL(LV_RST)) u_lvl (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ad_i, wr_n_i, rd_n_i, cs_n_i, ale_i}),
        .q     (lvl)
    );

    ctl_edge #(.W(EV_NUM), .STAGES(SYNC_STAGES), .RST_VAL(EV_RST),
               .FALL_MASK(EV_FALL)) u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk_i, wr_n_i, ale_i}),
        .evt   (evt)
    );

    assign bus_d = lvl[LVW-1:LV_NUM];

    logic          ser_mode;
    logic          p_we, s_we;
    logic [AW-1:0] p_addr, s_addr;
    logic [DW-1:0] p_wdata, s_wdata, p_rdata, s_rdata;
    logic [DW-1:0] p_drv, p_oe;
    logic          s_bit, s_oe;

    ctl_par_engine #(.AW(AW), .DW(DW)) u_par (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_mode (ser_mode),
        .ale_fall (evt[EV_ALE_FALL]),
        .cs_lvl_n (lvl[LV_CS]),
        .rd_lvl_n (lvl[LV_RD]),
        .wr_lvl_n (lvl[LV_WR]),
        .wr_rise  (evt[EV_WR_RISE]),
        .bus_d    (bus_d),
        .we       (p_we),
        .addr     (p_addr),
        .wdata    (p_wdata),
        .rdata    (p_rdata),
        .drv_d    (p_drv),
        .drv_oe   (p_oe)
    );

    ctl_ser_engine #(.AW(AW), .DW(DW), .STRAP_CYCLES(STRAP_CYCLES)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_cond (lvl[LV_ALE] && !lvl[LV_CS]),
        .rd_lvl_n   (lvl[LV_RD]),
        .wr_rise    (evt[EV_WR_RISE]),
        .sclk_fall  (evt[EV_SCLK_FALL]),
        .din        (bus_d[DW-1]),
        .addr_in    (bus_d[AW-1:0]),
        .ser_mode   (ser_mode),
        .we         (s_we),
        .addr       (s_addr),
        .wdata      (s_wdata),
        .rdata      (s_rdata),
        .drv_bit    (s_bit),
        .drv_oe     (s_oe)
    );

    ctl_regbank #(.AW(AW), .DW(DW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .par_we   (p_we),
        .par_addr (p_addr),
        .par_data (p_wdata),
        .ser_we   (s_we),
        .ser_addr (s_addr),
        .ser_data (s_wdata),
        .raddr_a  (p_addr),
        .rdata_a  (p_rdata),
        .raddr_b  (s_addr),
        .rdata_b  (s_rdata)
    );

    always_comb begin
        ad_o    = p_drv;
        ad_oe_o = p_oe;
        if (s_oe) begin
            ad_o[DW-1]    = s_bit;
            ad_oe_o[DW-1] = 1'b1;
        end
    end

    // Only the serial data line may be enabled in serial mode
    assert_ser_lines_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ser_mode |-> ad_oe_o[DW-2:0] == '0);

    // Enables are all-or-nothing in parallel mode
    assert_par_oe_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_mode |-> (ad_oe_o == '0 || ad_oe_o == '1));

endmodule

// File: tb/tb_ctl_regport.sv
module tb_ctl_regport;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ale_i, cs_n_i, rd_n_i, wr_n_i, sclk_i;
    logic [7:0] ad_i;
    logic [7:0] ad_o, ad_oe_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    ctl_regport dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .ale_i   (ale_i),
        .cs_n_i  (cs_n_i),
        .rd_n_i  (rd_n_i),
        .wr_n_i  (wr_n_i),
        .sclk_i  (sclk_i),
        .ad_i    (ad_i),
        .ad_o    (ad_o),
        .ad_oe_o (ad_oe_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Parallel helpers
    task automatic par_latch(input logic [2:0] a, input logic csn);
        cs_n_i = csn; ad_i = {5'b0, a}; tick(2);
        ale_i = 1'b1; tick(3);
        ale_i = 1'b0; tick(4);
        ad_i = 8'h00;
    endtask

    task automatic par_write(input logic [2:0] a, input logic [7:0] v, input logic csn);
        par_latch(a, csn);
        ad_i = v; wr_n_i = 1'b0; tick(4);
        wr_n_i = 1'b1; tick(4);
        ad_i = 8'h00; cs_n_i = 1'b1; tick(2);
    endtask

    task automatic par_read(input string req, input logic [2:0] a, input logic [7:0] exp);
        par_latch(a, 1'b0);
        ad_i = 8'hE7;
        rd_n_i = 1'b0; tick(5);
        check(req, ad_oe_o, 8'hFF);
        check(req, ad_o, exp);
        rd_n_i = 1'b1; tick(5);
        check(req, ad_oe_o, 8'h00);
        ad_i = 8'h00; cs_n_i = 1'b1; tick(2);
    endtask

    // Serial helpers
    task automatic ser_bit(input logic b);
        ad_i[7] = b; tick(3);
        sclk_i = 1'b0; tick(4);
        sclk_i = 1'b1; tick(3);
    endtask

    task automatic ser_shift(input logic [7:0] v);
        for (int i = 0; i < 8; i++) ser_bit(v[i]);
    endtask

    task automatic ser_commit();
        wr_n_i = 1'b0; tick(4);
        wr_n_i = 1'b1; tick(4);
    endtask

    task automatic ser_read(input string req, input logic [2:0] a, input logic [7:0] exp);
        ad_i = {5'b0, a}; tick(3);
        rd_n_i = 1'b0; tick(5);
        check(req, ad_oe_o, 8'h80);
        check(req, {7'b0, ad_o[7]}, {7'b0, exp[0]});
        for (int i = 1; i < 8; i++) begin
            sclk_i = 1'b0; tick(5);
            check(req, {7'b0, ad_o[7]}, {7'b0, exp[i]});
            sclk_i = 1'b1; tick(3);
        end
        rd_n_i = 1'b1; tick(5);
        check(req, ad_oe_o, 8'h00);
    endtask

    // Scenarios
    task automatic t_reset();
        rst_n = 1'b0; ale_i = 1'b0; cs_n_i = 1'b1; rd_n_i = 1'b1;
        wr_n_i = 1'b1; sclk_i = 1'b1; ad_i = 8'h00;
        tick(5);
        rst_n = 1'b1; tick(3);
        check("R1 oe after reset", ad_oe_o, 8'h00);
        par_read("R1 reg0 reset", 3'd0, 8'h00);
        par_read("R1 reg7 reset", 3'd7, 8'h00);
    endtask

    task automatic t_par_basic();
        par_write(3'd3, 8'hA5, 1'b0);
        par_write(3'd5, 8'h3C, 1'b0);
        par_read("R3 write reg3", 3'd3, 8'hA5);
        par_read("R2 latched address reg5", 3'd5, 8'h3C);
        par_read("R5 neighbour reg4 untouched", 3'd4, 8'h00);
    endtask

    task automatic t_par_cs_high();
        par_write(3'd3, 8'hFF, 1'b1);
        par_read("R4 write with cs high ignored", 3'd3, 8'hA5);
        par_latch(3'd3, 1'b1);
        rd_n_i = 1'b0; tick(5);
        check("R4 read with cs high not driven", ad_oe_o, 8'h00);
        rd_n_i = 1'b1; tick(3);
    endtask

    task automatic t_strap();
        ale_i = 1'b1; cs_n_i = 1'b0; ad_i = 8'h03; tick(10);
        rd_n_i = 1'b0; tick(5);
        check("R6 short strap stays parallel", ad_oe_o, 8'h00);
        rd_n_i = 1'b1; tick(40);
        ser_read("R6 R8 serial read of reg3", 3'd3, 8'hA5);
    endtask

    task automatic t_ser_write();
        ad_i = 8'h06; tick(2);
        ser_shift(8'h96);
        ser_commit();
        ser_read("R7 serial write reg6", 3'd6, 8'h96);
    endtask

    task automatic t_ser_overshift();
        ad_i = 8'h01; tick(2);
        ser_bit(1'b1);
        ser_bit(1'b1);
        ser_shift(8'h5A);
        ser_commit();
        ser_read("R10 last eight bits kept", 3'd1, 8'h5A);
    endtask

    task automatic t_ser_same_cycle();
        ad_i = 8'h02; tick(2);
        ser_shift(8'hC3);
        ad_i[7] = 1'b1; tick(3);
        wr_n_i = 1'b0; tick(4);
        sclk_i = 1'b0; wr_n_i = 1'b1; tick(4);
        sclk_i = 1'b1; tick(4);
        ser_read("R9 commit takes pre-shift byte", 3'd2, 8'hC3);
    endtask

    task automatic t_back_to_par();
        ale_i = 1'b0; cs_n_i = 1'b1; ad_i = 8'h00; tick(6);
        par_read("R7 serial value in parallel mode", 3'd6, 8'h96);
        par_read("R9 reg2 in parallel mode", 3'd2, 8'hC3);
    endtask

    initial begin
        #(5ns * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_par_basic();
        t_par_cs_high();
        t_strap();
        t_ser_write();
        t_ser_overshift();
        t_ser_same_cycle();
        t_back_to_par();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule